// File: doc/BRIEF.md
# Object Persistence Check Unit

This unit decides the outcome of one checked access to a managed object in a runtime that must keep every object reachable from persistent memory inside persistent memory. Each request carries an operation kind, the base address of the host object and, for reference stores, the base address of the object being stored. Together with these come the hit results of two membership filters, one for objects that have moved and one for objects whose migration is still in progress, and a bit that says a transaction is active. All filter lookups are keyed on object base addresses, never on field addresses. The unit classifies each base address as persistent or volatile against a programmable window. It then runs an ordered series of tests and returns one action code one clock later.

The tests that run depend on the operation kind and on where the host lives. A reference store runs up to four tests, a primitive store two, and a load one. Only the first test that fires is reported. The software handler that takes a trap resolves the condition and then issues the access again, so conditions later in the order are reported on that second pass.

Top module: `opc_check_unit`

## Requirements
- R1: An address A is persistent when nvm_base <= A < nvm_limit (limit exclusive in the default build). Every other address is volatile, including A equal to nvm_limit and A equal to nvm_base-1.
- R2: For any load, primitive store or reference store whose host base is volatile and whose host forward filter hits, the action is 1 (translate host). This test outranks every other test.
- R3: For a reference store whose host is persistent, whose value base is volatile and whose queued filter hits, the action is 3 (wait), unless R2 applies. No other kind of operation ever returns 3, and a volatile host never produces it.
- R4: For a reference store where neither R2 nor R3 applies and the value forward filter hits, the action is 2 (translate value). The region of the value base plays no part in this test.
- R5: For a reference store where R2 to R4 do not apply and txn_active is high with a persistent host, the action is 4 (log before store). Otherwise the action is 0 (proceed).
- R6: A primitive store returns 1 under R2. Otherwise it returns 4 when txn_active is high and the host is persistent, and 0 in every other case. It never consults the value base or the value filters.
- R7: A load returns 1 under R2 and 0 otherwise. It ignores txn_active and the value inputs.
- R8: Operation codes are 0 load, 1 primitive store, 2 reference store. Code 3 is reserved and always returns 0.
- R9: Exactly one action code is reported per request. It is the first condition that fires in the order given by R2 to R6.
- R10: rsp_valid is req_valid delayed by one clock, and rsp_action belongs to the request of the previous clock. rsp_action is 0 whenever rsp_valid is low.
- R11: While reset is asserted and just after it, rsp_valid is 0 and rsp_action is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | A request is present this cycle |
| req_op | input | 2 | Operation kind (R8 encoding) |
| host_base | input | AW | Base address of the host object |
| value_base | input | AW | Base address of the stored object (reference store) |
| nvm_base | input | AW | First persistent address |
| nvm_limit | input | AW | End of the persistent window |
| txn_active | input | 1 | Transaction in progress |
| host_fwd_hit | input | 1 | Forward filter hit for host_base |
| value_fwd_hit | input | 1 | Forward filter hit for value_base |
| value_queued_hit | input | 1 | Queued filter hit for value_base |
| rsp_valid | output | 1 | Result is present |
| rsp_action | output | 3 | 0 proceed, 1 translate host, 2 translate value, 3 wait, 4 log before store |

## Verification
The assertions assume that the filter hit inputs and the window bounds are stable for the cycle in which req_valid is high. They also assume that the reserved operation code may arrive and must be answered harmlessly. The bench holds the window fixed with nvm_base below nvm_limit and presents one request per cycle. It sweeps every combination of operation code, host region, value region, transaction bit and the three filter hits, using addresses well inside each region. It then probes addresses at both edges of the window.

// File: rtl/opc_pkg.sv
package opc_pkg;
   typedef enum logic [1:0] {
      OP_LOAD  = 2'd0,
      OP_PRIM  = 2'd1,
      OP_REF   = 2'd2,
      OP_RSVD  = 2'd3
   } op_e;

   typedef enum logic [2:0] {
      ACT_PROCEED    = 3'd0,
      ACT_HOST_XLATE = 3'd1,
      ACT_VAL_XLATE  = 3'd2,
      ACT_WAIT       = 3'd3,
      ACT_LOG        = 3'd4
   } act_e;
endpackage

// File: rtl/opc_region.sv
module opc_region #(
   parameter int AW = 8,
   parameter bit LIMIT_INCLUSIVE = 1'b0
) (
   input  logic [AW-1:0] addr,
   input  logic [AW-1:0] lo,
   input  logic [AW-1:0] hi,
   output logic          is_nvm
);
   logic above_lo;
   logic below_hi;

   assign above_lo = (addr >= lo);

   generate
      if (LIMIT_INCLUSIVE) begin : g_incl
         assign below_hi = (addr <= hi);
      end else begin : g_excl
         assign below_hi = (addr < hi);
      end
   endgenerate

   assign is_nvm = above_lo && below_hi;
endmodule

// File: rtl/opc_decide.sv
module opc_decide
   import opc_pkg::*;
(
   input  logic [1:0] op,
   input  logic       host_nvm,
   input  logic       value_nvm,
   input  logic       txn_active,
   input  logic       host_fwd_hit,
   input  logic       value_fwd_hit,
   input  logic       value_queued_hit,
   output logic [2:0] action
);
   logic host_moved;
   logic value_blocked;
   logic want_log;

   assign host_moved    = !host_nvm && host_fwd_hit;
   assign value_blocked = host_nvm && !value_nvm && value_queued_hit;
   assign want_log      = txn_active && host_nvm;

   always_comb begin
      action = ACT_PROCEED;
      case (op)
         OP_REF: begin
            if (host_moved)         action = ACT_HOST_XLATE;
            else if (value_blocked) action = ACT_WAIT;
            else if (value_fwd_hit) action = ACT_VAL_XLATE;
            else if (want_log)      action = ACT_LOG;
         end
         OP_PRIM: begin
            if (host_moved)         action = ACT_HOST_XLATE;
            else if (want_log)      action = ACT_LOG;
         end
         OP_LOAD: begin
            if (host_moved)         action = ACT_HOST_XLATE;
         end
         default: action = ACT_PROCEED;
      endcase
   end
endmodule

// File: rtl/opc_check_unit.sv
module opc_check_unit
   import opc_pkg::*;
#(
   parameter int AW = 8,
   parameter bit LIMIT_INCLUSIVE = 1'b0
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          req_valid,
   input  logic [1:0]    req_op,
   input  logic [AW-1:0] host_base,
   input  logic [AW-1:0] value_base,
   input  logic [AW-1:0] nvm_base,
   input  logic [AW-1:0] nvm_limit,
   input  logic          txn_active,
   input  logic          host_fwd_hit,
   input  logic          value_fwd_hit,
   input  logic          value_queued_hit,
   output logic          rsp_valid,
   output logic [2:0]    rsp_action
);
   localparam int MIN_AW = 2;

   initial begin
      if (AW < MIN_AW) $fatal(1, "opc_check_unit: AW must be at least %0d", MIN_AW);
   end

   logic       host_nvm;
   logic       value_nvm;
   logic [2:0] next_action;

   opc_region #(.AW(AW), .LIMIT_INCLUSIVE(LIMIT_INCLUSIVE)) u_host_region (
      .addr   (host_base),
      .lo     (nvm_base),
      .hi     (nvm_limit),
      .is_nvm (host_nvm)
   );

   opc_region #(.AW(AW), .LIMIT_INCLUSIVE(LIMIT_INCLUSIVE)) u_value_region (
      .addr   (value_base),
      .lo     (nvm_base),
      .hi     (nvm_limit),
      .is_nvm (value_nvm)
   );

   opc_decide u_decide (
      .op               (req_op),
      .host_nvm         (host_nvm),
      .value_nvm        (value_nvm),
      .txn_active       (txn_active),
      .host_fwd_hit     (host_fwd_hit),
      .value_fwd_hit    (value_fwd_hit),
      .value_queued_hit (value_queued_hit),
      .action           (next_action)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         rsp_valid  <= 1'b0;
         rsp_action <= ACT_PROCEED;
      end else begin
         rsp_valid  <= req_valid;
         rsp_action <= req_valid ? next_action : ACT_PROCEED;
      end
   end
endmodule

// File: rtl/opc_check_unit_sva.sv
module opc_check_unit_sva
   import opc_pkg::*;
(
   input logic       clk,
   input logic       rst_n,
   input logic       req_valid,
   input logic [1:0] req_op,
   input logic       host_fwd_hit,
   input logic       rsp_valid,
   input logic [2:0] rsp_action
);
   a_r10_valid_follows: assert property (@(posedge clk) disable iff (!rst_n)
      req_valid |=> rsp_valid);
   a_r10_idle_follows: assert property (@(posedge clk) disable iff (!rst_n)
      !req_valid |=> (!rsp_valid && rsp_action == ACT_PROCEED));
   a_r7_load_actions: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && req_op == OP_LOAD) |=>
         (rsp_action == ACT_PROCEED || rsp_action == ACT_HOST_XLATE));
   a_r3_wait_ref_only: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && req_op != OP_REF) |=> (rsp_action != ACT_WAIT));
   a_r6_prim_no_value: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && req_op == OP_PRIM) |=>
         (rsp_action != ACT_WAIT && rsp_action != ACT_VAL_XLATE));
   a_r8_reserved_proceeds: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && req_op == OP_RSVD) |=> (rsp_action == ACT_PROCEED));
   a_r2_host_needs_hit: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && !host_fwd_hit) |=> (rsp_action != ACT_HOST_XLATE));
   a_r9_code_legal: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_action <= ACT_LOG);
endmodule

bind opc_check_unit opc_check_unit_sva u_sva (
   .clk          (clk),
   .rst_n        (rst_n),
   .req_valid    (req_valid),
   .req_op       (req_op),
   .host_fwd_hit (host_fwd_hit),
   .rsp_valid    (rsp_valid),
   .rsp_action   (rsp_action)
);

// File: tb/opc_check_unit_bench.sv
module opc_check_unit_bench;
   localparam int CLK_PERIOD = 10;
   localparam int AW = 8;
   localparam logic [AW-1:0] WIN_LO = 8'h40;
   localparam logic [AW-1:0] WIN_HI = 8'hC0;
   localparam logic [AW-1:0] A_DRAM = 8'h10;
   localparam logic [AW-1:0] A_NVM  = 8'h80;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          req_valid = 1'b0;
   logic [1:0]    req_op = 2'd0;
   logic [AW-1:0] host_base = '0;
   logic [AW-1:0] value_base = '0;
   logic [AW-1:0] nvm_base = WIN_LO;
   logic [AW-1:0] nvm_limit = WIN_HI;
   logic          txn_active = 1'b0;
   logic          host_fwd_hit = 1'b0;
   logic          value_fwd_hit = 1'b0;
   logic          value_queued_hit = 1'b0;
   logic          rsp_valid;
   logic [2:0]    rsp_action;

   int checks = 0;
   int failures = 0;
   bit done = 1'b0;

   always #(CLK_PERIOD/2) clk = ~clk;

   opc_check_unit #(.AW(AW)) u_opc_check_unit (
      .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_op(req_op),
      .host_base(host_base), .value_base(value_base),
      .nvm_base(nvm_base), .nvm_limit(nvm_limit), .txn_active(txn_active),
      .host_fwd_hit(host_fwd_hit), .value_fwd_hit(value_fwd_hit),
      .value_queued_hit(value_queued_hit),
      .rsp_valid(rsp_valid), .rsp_action(rsp_action)
   );

   function automatic bit in_win(logic [AW-1:0] a);
      return (a >= WIN_LO) && (a < WIN_HI);
   endfunction

   function automatic logic [2:0] model(logic [1:0] op, bit hn, bit vn, bit tx,
                                        bit hf, bit vf, bit vq);
      if (op == 2'd3) return 3'd0;
      if (!hn && hf) return 3'd1;
      if (op == 2'd0) return 3'd0;
      if (op == 2'd2) begin
         if (hn && !vn && vq) return 3'd3;
         if (vf) return 3'd2;
      end
      if (tx && hn) return 3'd4;
      return 3'd0;
   endfunction

   task automatic check(string tag, logic [2:0] got, logic [2:0] exp);
      checks++;
      if (got !== exp) begin
         failures++;
         $display("FAIL %s: got %0d expected %0d", tag, got, exp);
      end
   endtask

   task automatic run_one(string tag, logic [1:0] op, logic [AW-1:0] hb,
                          logic [AW-1:0] vb, bit tx, bit hf, bit vf, bit vq);
      logic [2:0] exp;
      exp = model(op, in_win(hb), in_win(vb), tx, hf, vf, vq);
      @(negedge clk);
      req_valid = 1'b1; req_op = op; host_base = hb; value_base = vb;
      txn_active = tx; host_fwd_hit = hf; value_fwd_hit = vf; value_queued_hit = vq;
      @(negedge clk);
      req_valid = 1'b0;
      check({tag, " R10 valid"}, {2'b0, rsp_valid}, 3'd1);
      check(tag, rsp_action, exp);
   endtask

   function automatic string tag_for(logic [1:0] op, logic [2:0] e);
      if (op == 2'd3) return "R8";
      if (op == 2'd0) return "R7";
      if (op == 2'd1) return "R6";
      case (e)
         3'd1: return "R2";
         3'd3: return "R3";
         3'd2: return "R4";
         default: return "R5 R9";
      endcase
   endfunction

   initial begin
      repeat (3) @(negedge clk);
      check("R11 reset valid", {2'b0, rsp_valid}, 3'd0);
      check("R11 reset action", rsp_action, 3'd0);
      rst_n = 1'b1;
      @(negedge clk);
      check("R11 after reset valid", {2'b0, rsp_valid}, 3'd0);

      for (int i = 0; i < 256; i++) begin
         logic [1:0] op;
         logic [AW-1:0] hb, vb;
         logic [2:0] e;
         op = i[7:6];
         hb = i[5] ? A_NVM : A_DRAM;
         vb = i[4] ? A_NVM : A_DRAM;
         e  = model(op, i[5], i[4], i[3], i[2], i[1], i[0]);
         run_one(tag_for(op, e), op, hb, vb, i[3], i[2], i[1], i[0]);
      end

      // R1 window edges, probed with a primitive store under a transaction
      run_one("R1 at base",    2'd1, WIN_LO,      A_DRAM, 1'b1, 1'b0, 1'b0, 1'b0);
      run_one("R1 below base", 2'd1, WIN_LO - 1,  A_DRAM, 1'b1, 1'b1, 1'b0, 1'b0);
      run_one("R1 at limit",   2'd1, WIN_HI,      A_DRAM, 1'b1, 1'b1, 1'b0, 1'b0);
      run_one("R1 below limit",2'd1, WIN_HI - 1,  A_DRAM, 1'b1, 1'b0, 1'b0, 1'b0);
      run_one("R1 value at limit R3", 2'd2, A_NVM, WIN_HI, 1'b0, 1'b0, 1'b0, 1'b1);
      run_one("R1 value at base R3",  2'd2, A_NVM, WIN_LO, 1'b0, 1'b0, 1'b0, 1'b1);

      // R10 idle cycle after traffic
      @(negedge clk);
      check("R10 idle valid", {2'b0, rsp_valid}, 3'd0);
      check("R10 idle action", rsp_action, 3'd0);
      done = 1'b1;
   end

   initial begin
      fork
         wait (done);
         begin
            repeat (100000) @(posedge clk);
            checks++;
            failures++;
            $display("FAIL watchdog: got timeout expected completion");
         end
      join_any
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end
endmodule